// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Control Core

This block is the digital heart of a transceiver for a single-wire, variable-pulse-width vehicle bus. It takes the network standby control, a three-level transmit-mode control (presented as a two-bit code by the pin front end), the transmit data bit, the bus comparator output, an over-temperature flag and a supply-good indication. From these it decides whether the bus driver may drive, whether waveshaping is bypassed for fast edges, what the active-low receive output shows, and whether the transmitter is latched off after a thermal event.

All control inputs are resynchronised to the core clock. The bus comparator path is also glitch-filtered, so a short spike on the wire never reaches the receive output. Analog drive, slope shaping, thresholds and pin biasing stay outside. Only their digital enables and the indications they return are modelled here.

Top module: `vpw_xcvr_ctl`

## Requirements
- R1: After reset, drv_en_o=0, fast_edge_o=0, rx_n_o=1 and tx_off_o=0.
- R2: Normal mode is standby_i=1, pwr_ok_i=1 and mode_code_i=2'b00. In this mode drv_en_o follows tx_i, fast_edge_o=0 and rx_n_o is the inverse of the filtered bus_cmp_i, where 1 means the bus is above threshold.
- R3: Fast mode is standby_i=1, pwr_ok_i=1 and mode_code_i=2'b01. In this mode drv_en_o follows tx_i and fast_edge_o=1. fast_edge_o is 0 in every other mode.
- R4: Loopback mode is standby_i=1, pwr_ok_i=1 and mode_code_i of 2'b10 (floating) or 2'b11. In this mode drv_en_o=0 whatever tx_i is, and rx_n_o is the inverse of tx_i, with bus_cmp_i ignored.
- R5: While standby_i=0 or pwr_ok_i=0, drv_en_o=0 and fast_edge_o=0 whatever tx_i and mode_code_i are. rx_n_o still reports the inverse of the filtered bus state.
- R6: Once ovt_i is asserted, tx_off_o becomes 1 and drv_en_o is 0 even with tx_i high in normal or fast mode.
- R7: tx_off_o clears only on a rising edge of tx_i seen while ovt_i is low. A tx_i edge while ovt_i is high does not clear it, and cooling alone without a later tx_i edge leaves it set.
- R8: A bus_cmp_i level change that lasts fewer than FILT_LEN clocks (default 4) never reaches rx_n_o. A level held for longer does reach it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Network standby control, 1 enables transmit |
| mode_code_i | input | 2 | Transmit mode: 00 low, 01 high, 10 floating, 11 treated as floating |
| tx_i | input | 1 | Transmit data, 1 means drive bus active |
| bus_cmp_i | input | 1 | Bus comparator, 1 means bus above receive threshold |
| ovt_i | input | 1 | Die over-temperature flag |
| pwr_ok_i | input | 1 | Supply controller reports power good |
| drv_en_o | output | 1 | Bus driver enable |
| fast_edge_o | output | 1 | Waveshaping bypass |
| rx_n_o | output | 1 | Active-low receive data |
| tx_off_o | output | 1 | Transmitter latched off by thermal event |

## Verification
The bench goes after the thermal latch clearing order. It raises tx_i while still hot, then cools with tx_i held high, then makes a clean edge. A design that cleared on cooling, or on an edge seen while hot, would show drv_en_o high too early. Short bus spikes of FILT_LEN-1 clocks are watched on every cycle, so a filter that is too short shows up as a brief low pulse on rx_n_o even when the output settles back. Loopback is exercised with the bus held active and with code 11. A decoder that treated 11 as fast mode, or that let the bus leak into loopback receive, would drive the wire or report the wrong receive level.

// File: rtl/vpw_ctl_pkg.sv
package vpw_ctl_pkg;
   typedef enum logic [1:0] {
      XM_STBY   = 2'd0,
      XM_NORMAL = 2'd1,
      XM_FAST   = 2'd2,
      XM_LOOP   = 2'd3
   } xcvr_mode_e;

   localparam logic [1:0] MCODE_LOW  = 2'b00;
   localparam logic [1:0] MCODE_HIGH = 2'b01;
endpackage

// File: rtl/vpw_sync.sv
module vpw_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vpw_sync needs at least two stages");
      end
      if (W < 1) begin : g_bad_width
         $error("vpw_sync width must be positive");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[gi] <= '0;
            end else begin
               if (gi == 0) stage_q[gi] <= d_i;
               else         stage_q[gi] <= stage_q[(gi == 0) ? 0 : gi-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/vpw_glitch_filter.sv
module vpw_glitch_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_i,
   output logic out_o
);
   localparam int CNT_W = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'((FILT_LEN < 1) ? 0 : FILT_LEN - 1);

   generate
      if (FILT_LEN < 0) begin : g_bad_len
         $error("vpw_glitch_filter length must not be negative");
      end

      if (FILT_LEN == 0) begin : g_bypass
         assign out_o = in_i;
      end else begin : g_count
         logic [CNT_W-1:0] run_cnt;
         logic             level_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_cnt <= '0;
               level_q <= 1'b0;
            end else if (in_i == level_q) begin
               run_cnt <= '0;
            end else if (run_cnt == CNT_LAST) begin
               run_cnt <= '0;
               level_q <= in_i;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end

         assign out_o = level_q;

         // R8: a difference that has not lasted FILT_LEN samples must not move the output
         assert_short_pulse_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ((in_i != level_q) && (run_cnt != CNT_LAST)) |=> $stable(level_q));
         // R8: the output never moves while input already agrees with it
         assert_no_spurious_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (in_i == level_q) |=> $stable(level_q));
      end
   endgenerate
endmodule

// File: rtl/vpw_mode_decode.sv
module vpw_mode_decode
   import vpw_ctl_pkg::*;
(
   input  logic       standby_s,
   input  logic       pwr_ok_s,
   input  logic [1:0] mode_code_s,
   output xcvr_mode_e mode_o
);
   always_comb begin
      if (!standby_s || !pwr_ok_s) begin
         mode_o = XM_STBY;
      end else begin
         unique case (mode_code_s)
            MCODE_LOW:  mode_o = XM_NORMAL;
            MCODE_HIGH: mode_o = XM_FAST;
            default:    mode_o = XM_LOOP;
         endcase
      end
   end
endmodule

// File: rtl/vpw_ovt_latch.sv
module vpw_ovt_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic ovt_s,
   input  logic tx_s,
   output logic off_o
);
   logic tx_prev;
   logic tx_rise;
   logic off_q;

   assign tx_rise = tx_s && !tx_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_prev <= 1'b0;
         off_q   <= 1'b0;
      end else begin
         tx_prev <= tx_s;
         if (ovt_s)        off_q <= 1'b1;
         else if (tx_rise) off_q <= 1'b0;
      end
   end

   assign off_o = off_q;

   // R6: a hot die always ends up latched off
   assert_hot_sets_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ovt_s |=> off_q);
   // R7: no clearing while the flag is still up, even on a transmit edge
   assert_hot_holds_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (off_q && ovt_s) |=> off_q);
   // R7: cooling alone does not clear; a transmit rising edge is needed
   assert_clear_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (off_q && !(tx_s && !tx_prev)) |=> off_q);
endmodule

// File: rtl/vpw_xcvr_ctl.sv
module vpw_xcvr_ctl
   import vpw_ctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       standby_i,
   input  logic [1:0] mode_code_i,
   input  logic       tx_i,
   input  logic       bus_cmp_i,
   input  logic       ovt_i,
   input  logic       pwr_ok_i,
   output logic       drv_en_o,
   output logic       fast_edge_o,
   output logic       rx_n_o,
   output logic       tx_off_o
);
   localparam int CTL_W = 6;

   generate
      if (FILT_LEN > 4096) begin : g_bad_filt
         $error("vpw_xcvr_ctl filter length out of range");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_raw, ctl_s;
   logic             standby_s, tx_s, ovt_s, pwr_ok_s;
   logic [1:0]       mode_code_s;
   logic             bus_s, bus_f;
   logic             off_flag;
   xcvr_mode_e       cur_mode;
   logic             drv_q, fast_q, rxn_q;

   assign ctl_raw = {pwr_ok_i, ovt_i, tx_i, standby_i, mode_code_i};

   vpw_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s)
   );

   assign {pwr_ok_s, ovt_s, tx_s, standby_s, mode_code_s} = ctl_s;

   vpw_sync #(.W(1), .STAGES(SYNC_STAGES)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d_i(bus_cmp_i), .q_o(bus_s)
   );

   vpw_glitch_filter #(.FILT_LEN(FILT_LEN)) u_bus_filt (
      .clk(clk), .rst_n(rst_n), .in_i(bus_s), .out_o(bus_f)
   );

   vpw_mode_decode u_dec (
      .standby_s(standby_s), .pwr_ok_s(pwr_ok_s),
      .mode_code_s(mode_code_s), .mode_o(cur_mode)
   );

   vpw_ovt_latch u_ovt (
      .clk(clk), .rst_n(rst_n), .ovt_s(ovt_s), .tx_s(tx_s), .off_o(off_flag)
   );

   logic may_drive;
   assign may_drive = (cur_mode == XM_NORMAL) || (cur_mode == XM_FAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q  <= 1'b0;
         fast_q <= 1'b0;
         rxn_q  <= 1'b1;
      end else begin
         drv_q  <= may_drive && tx_s && !off_flag && !ovt_s;
         fast_q <= (cur_mode == XM_FAST);
         rxn_q  <= (cur_mode == XM_LOOP) ? !tx_s : !bus_f;
      end
   end

   assign drv_en_o    = drv_q;
   assign fast_edge_o = fast_q;
   assign rx_n_o      = rxn_q;
   assign tx_off_o    = off_flag;

   // R4: loopback keeps the driver passive and echoes transmit
   assert_loop_passive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == XM_LOOP) |=> !drv_en_o);
   assert_loop_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == XM_LOOP) |=> (rx_n_o == !$past(tx_s)));
   // R5: standby or no power keeps the transmitter off
   assert_stby_passive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == XM_STBY) |=> (!drv_en_o && !fast_edge_o));
   // R6: a latched-off transmitter never drives
   assert_off_passive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      off_flag |=> !drv_en_o);
   // R3: the bypass only follows fast mode
   assert_fast_only_hs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode != XM_FAST) |=> !fast_edge_o);
endmodule

// File: tb/sim_vpw_xcvr_ctl.sv
module sim_vpw_xcvr_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 12;
   localparam int FLEN       = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic standby_i = 1'b0, tx_i = 1'b0, bus_cmp_i = 1'b0, ovt_i = 1'b0, pwr_ok_i = 1'b0;
   logic [1:0] mode_code_i = 2'b10;
   logic drv_en_o, fast_edge_o, rx_n_o, tx_off_o;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done = 0;

   typedef struct {
      logic  drv, fast, rxn, off;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   vpw_xcvr_ctl #(.SYNC_STAGES(2), .FILT_LEN(FLEN)) u0 (
      .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .mode_code_i(mode_code_i),
      .tx_i(tx_i), .bus_cmp_i(bus_cmp_i), .ovt_i(ovt_i), .pwr_ok_i(pwr_ok_i),
      .drv_en_o(drv_en_o), .fast_edge_o(fast_edge_o), .rx_n_o(rx_n_o), .tx_off_o(tx_off_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: pops expected items and compares at the falling edge
   always @(negedge clk) begin
      cycles++;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if ({drv_en_o, fast_edge_o, rx_n_o, tx_off_o} !== {e.drv, e.fast, e.rxn, e.off}) begin
            errors++;
            $display("FAIL %s: got drv=%b fast=%b rxn=%b off=%b expected drv=%b fast=%b rxn=%b off=%b",
                     e.tag, drv_en_o, fast_edge_o, rx_n_o, tx_off_o, e.drv, e.fast, e.rxn, e.off);
         end
      end
   end

   task automatic expect_out(input logic d, input logic f, input logic r, input logic o,
                             input string tag, input int wait_cyc = SETTLE);
      exp_t e;
      repeat (wait_cyc) @(posedge clk);
      e.drv = d; e.fast = f; e.rxn = r; e.off = o; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic set_in(input logic sb, input logic [1:0] mc, input logic t,
                         input logic b, input logic ov, input logic pw);
      @(negedge clk);
      standby_i = sb; mode_code_i = mc; tx_i = t; bus_cmp_i = b; ovt_i = ov; pwr_ok_i = pw;
   endtask

   // watch rx_n_o every cycle across a short bus spike
   task automatic spike_check(input int width, input string tag);
      bit seen_low = 0;
      @(negedge clk);
      bus_cmp_i = 1'b1;
      for (int k = 0; k < width; k++) begin
         @(negedge clk);
         if (rx_n_o !== 1'b1) seen_low = 1;
      end
      bus_cmp_i = 1'b0;
      for (int k = 0; k < SETTLE; k++) begin
         @(negedge clk);
         if (rx_n_o !== 1'b1) seen_low = 1;
      end
      checks++;
      if (seen_low) begin
         errors++;
         $display("FAIL %s: rx_n_o went to 0, expected to stay 1", tag);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      sb_q.push_back('{1'b0, 1'b0, 1'b1, 1'b0, "R1 reset"});
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;

      // R2: normal mode, several patterns
      set_in(1, 2'b00, 1, 0, 0, 1);
      expect_out(1, 0, 1, 0, "R2 normal tx=1 bus idle");
      set_in(1, 2'b00, 1, 1, 0, 1);
      expect_out(1, 0, 0, 0, "R2 normal tx=1 bus active");
      set_in(1, 2'b00, 0, 1, 0, 1);
      expect_out(0, 0, 0, 0, "R2 normal tx=0 bus active");
      set_in(1, 2'b00, 0, 0, 0, 1);
      expect_out(0, 0, 1, 0, "R2 normal tx=0 bus idle");

      // R8: spikes shorter than FILT_LEN are invisible, longer ones pass
      spike_check(FLEN - 1, "R8 short spike");
      spike_check(1, "R8 single-cycle spike");
      set_in(1, 2'b00, 0, 1, 0, 1);
      expect_out(0, 0, 0, 0, "R8 long level passes", FLEN + 4);
      set_in(1, 2'b00, 0, 0, 0, 1);
      expect_out(0, 0, 1, 0, "R8 return to idle");

      // R3: fast mode
      set_in(1, 2'b01, 1, 0, 0, 1);
      expect_out(1, 1, 1, 0, "R3 fast tx=1");
      set_in(1, 2'b01, 0, 1, 0, 1);
      expect_out(0, 1, 0, 0, "R3 fast tx=0 bus active");

      // R4: loopback, bus ignored, code 11 same as 10
      set_in(1, 2'b10, 1, 0, 0, 1);
      expect_out(0, 0, 0, 0, "R4 loop tx=1");
      set_in(1, 2'b10, 0, 1, 0, 1);
      expect_out(0, 0, 1, 0, "R4 loop tx=0 bus active ignored");
      set_in(1, 2'b11, 1, 1, 0, 1);
      expect_out(0, 0, 0, 0, "R4 code 11 loop tx=1");
      set_in(1, 2'b11, 0, 1, 0, 1);
      expect_out(0, 0, 1, 0, "R4 code 11 loop tx=0");

      // R5: standby low, power low
      set_in(0, 2'b01, 1, 1, 0, 1);
      expect_out(0, 0, 0, 0, "R5 standby low bus active");
      set_in(0, 2'b00, 1, 0, 0, 1);
      expect_out(0, 0, 1, 0, "R5 standby low bus idle");
      set_in(1, 2'b01, 1, 1, 0, 0);
      expect_out(0, 0, 0, 0, "R5 power low");

      // R6 / R7: thermal latch sequence in normal mode
      set_in(1, 2'b00, 0, 0, 0, 1);
      expect_out(0, 0, 1, 0, "R7 setup");
      set_in(1, 2'b00, 0, 0, 1, 1);
      expect_out(0, 0, 1, 1, "R6 hot latches");
      set_in(1, 2'b00, 1, 0, 1, 1);
      expect_out(0, 0, 1, 1, "R7 tx edge while hot no clear");
      set_in(1, 2'b00, 1, 0, 0, 1);
      expect_out(0, 0, 1, 1, "R7 cooled without edge stays latched");
      set_in(1, 2'b00, 0, 0, 0, 1);
      expect_out(0, 0, 1, 1, "R7 tx low still latched");
      set_in(1, 2'b00, 1, 0, 0, 1);
      expect_out(1, 0, 1, 0, "R7 clean edge clears and drives");
      set_in(1, 2'b01, 1, 0, 1, 1);
      expect_out(0, 1, 1, 1, "R6 hot in fast mode with tx high");

      repeat (4) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule